// File: doc/BRIEF.md
# Cascaded 24-Bit Event Counter

This block counts events with an 8-bit lower stage and a 16-bit upper stage joined in cascade. The lower stage takes the low byte and the upper stage the top sixteen bits. A single-cycle count strobe advances the lower stage while the counter runs. Each time the lower stage rolls over from its maximum to zero, it raises a pending overflow flag and sends one pulse to the upper stage. The flag stays up until software clears it.

The upper stage models a start synchronizer, so it drops the first rollover pulse it receives after each start. After that first pulse it counts every rollover, including across its own wrap to zero. Count strobes are taken only from the second cycle of the run enable onward, which models the up-to-one-clock start error. A read strobe captures both stages and the flag together. One cycle later the block presents a 24-bit snapshot with a valid pulse. If the flag was set at capture, the snapshot's upper part is the captured upper value plus one, modulo 2^16.

Top module: `cascadeEventCounter`

## Requirements
- R1: While reset is asserted and on its release, lowCount, highCount, lowOvf, snapValid and snapValue are all zero.
- R2: While runEn is high, each cycle with cntPulse high adds one to lowCount, except in the first cycle of a run, when runEn has just risen. With runEn high and cntPulse low, lowCount holds.
- R3: cntPulse has no effect while runEn is low, and lowCount stays zero.
- R4: When a counted pulse moves lowCount from 0xFF to 0x00, lowOvf becomes 1 on the next cycle. It stays 1 while the counter runs and flagClr is low.
- R5: flagClr high makes lowOvf 0 on the next cycle. This holds even when a rollover happens in the same cycle.
- R6: Every lower rollover adds one to highCount, except the first rollover after a start, which is dropped. highCount changes only on a rollover.
- R7: highCount wraps from its maximum to zero on a rollover without losing a pulse. The next rollover adds one again.
- R8: runEn low clears lowCount, highCount and lowOvf on the next cycle. A new start drops the first upper pulse again.
- R9: snapValid is high for exactly the one cycle after a cycle with readStb high.
- R10: snapValue is {capturedHigh + capturedFlag, capturedLow}, with the upper part in bits 23:8 and the lower part in bits 7:0. The values are captured in the readStb cycle. The upper sum wraps modulo 2^16, and a clear flag leaves the values unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Level: high runs the counter, low stops and clears it |
| cntPulse | input | 1 | Single-cycle count-clock strobe |
| readStb | input | 1 | Single-cycle snapshot request |
| flagClr | input | 1 | Single-cycle clear of the overflow flag |
| lowCount | output | 8 | Raw lower stage |
| highCount | output | 16 | Raw upper stage |
| lowOvf | output | 1 | Pending lower-stage overflow flag |
| snapValid | output | 1 | Snapshot valid pulse |
| snapValue | output | 24 | Corrected 24-bit snapshot |

## Verification
The properties assume that cntPulse, readStb and flagClr are synchronous strobes that change only between clock edges. They also assume that runEn is a level whose rising edge marks a start. The stimulus drives every input just after the falling clock edge. It raises each strobe for whole cycles, and it starts a run only from a stopped state, so the dropped-pulse and first-cycle rules apply at known points. Reads are issued in cycles without a count strobe, except where a capture alongside a rollover is the point of the test. A second, narrow instance shares the same stimulus so that the upper-stage wrap and the wrapped correction can be reached in a short run.

// File: rtl/cec_pkg.sv
package cec_pkg;

  // Strobes from the control unit to the counter datapath and read unit.
  typedef struct packed {
    logic clearAll;
    logic lowInc;
    logic highInc;
    logic flagSet;
    logic flagClr;
    logic capture;
  } cecStrobes_t;

endpackage

// File: rtl/cecControl.sv
module cecControl
  import cec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        runEn,
  input  logic        cntPulse,
  input  logic        readStb,
  input  logic        flagClr,
  input  logic        lowAtMax,
  output cecStrobes_t stb
);

  logic runSeen;       // runEn seen on the previous cycle
  logic swallowPend;   // upper stage still waits for its first pulse
  logic wrapEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runSeen     <= 1'b0;
      swallowPend <= 1'b1;
    end else begin
      runSeen <= runEn;
      if (!runEn)
        swallowPend <= 1'b1;
      else if (wrapEv)
        swallowPend <= 1'b0;
    end
  end

  always_comb begin
    stb          = '0;
    stb.clearAll = ~runEn;
    stb.lowInc   = runEn & runSeen & cntPulse;
    wrapEv       = stb.lowInc & lowAtMax;
    stb.highInc  = wrapEv & ~swallowPend;
    stb.flagSet  = wrapEv;
    stb.flagClr  = flagClr;
    stb.capture  = readStb;
  end

endmodule

// File: rtl/cecDatapath.sv
module cecDatapath
  import cec_pkg::*;
#(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  cecStrobes_t       stb,
  output logic [LOW_W-1:0]  lowCount,
  output logic [HIGH_W-1:0] highCount,
  output logic              lowOvf,
  output logic              lowAtMax
);

  localparam logic [LOW_W-1:0]  LOW_ONE  = {{(LOW_W-1){1'b0}}, 1'b1};
  localparam logic [HIGH_W-1:0] HIGH_ONE = {{(HIGH_W-1){1'b0}}, 1'b1};

  assign lowAtMax = &lowCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCount <= '0;
    end else if (stb.clearAll) begin
      lowCount <= '0;
    end else if (stb.lowInc) begin
      lowCount <= lowCount + LOW_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highCount <= '0;
    end else if (stb.clearAll) begin
      highCount <= '0;
    end else if (stb.highInc) begin
      highCount <= highCount + HIGH_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowOvf <= 1'b0;
    end else if (stb.clearAll || stb.flagClr) begin
      lowOvf <= 1'b0;
    end else if (stb.flagSet) begin
      lowOvf <= 1'b1;
    end
  end

endmodule

// File: rtl/cecReadUnit.sv
module cecReadUnit #(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 16,
  localparam int TOTAL_W = LOW_W + HIGH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               capture,
  input  logic [LOW_W-1:0]   lowCount,
  input  logic [HIGH_W-1:0]  highCount,
  input  logic               lowOvf,
  output logic               snapValid,
  output logic [TOTAL_W-1:0] snapValue
);

  logic [LOW_W-1:0]  capLow;
  logic [HIGH_W-1:0] capHigh;
  logic              capFlag;
  logic [HIGH_W-1:0] fixedHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capLow    <= '0;
      capHigh   <= '0;
      capFlag   <= 1'b0;
      snapValid <= 1'b0;
    end else begin
      snapValid <= capture;
      if (capture) begin
        capLow  <= lowCount;
        capHigh <= highCount;
        capFlag <= lowOvf;
      end
    end
  end

  // A pending flag means the upper stage is one pulse behind.
  always_comb begin
    fixedHigh = capHigh + {{(HIGH_W-1){1'b0}}, capFlag};
    snapValue = {fixedHigh, capLow};
  end

endmodule

// File: rtl/cascadeEventCounter.sv
module cascadeEventCounter
  import cec_pkg::*;
#(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 16,
  localparam int TOTAL_W = LOW_W + HIGH_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic               cntPulse,
  input  logic               readStb,
  input  logic               flagClr,
  output logic [LOW_W-1:0]   lowCount,
  output logic [HIGH_W-1:0]  highCount,
  output logic               lowOvf,
  output logic               snapValid,
  output logic [TOTAL_W-1:0] snapValue
);

  cecStrobes_t stb;
  logic        lowAtMax;

  cecControl i_control (
    .clk      (clk),
    .rstN     (rstN),
    .runEn    (runEn),
    .cntPulse (cntPulse),
    .readStb  (readStb),
    .flagClr  (flagClr),
    .lowAtMax (lowAtMax),
    .stb      (stb)
  );

  cecDatapath #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .lowCount  (lowCount),
    .highCount (highCount),
    .lowOvf    (lowOvf),
    .lowAtMax  (lowAtMax)
  );

  cecReadUnit #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_readUnit (
    .clk       (clk),
    .rstN      (rstN),
    .capture   (stb.capture),
    .lowCount  (lowCount),
    .highCount (highCount),
    .lowOvf    (lowOvf),
    .snapValid (snapValid),
    .snapValue (snapValue)
  );

endmodule

// File: rtl/cecChecker.sv
module cecChecker #(
  parameter int LOW_W  = 8,
  parameter int HIGH_W = 16,
  localparam int TOTAL_W = LOW_W + HIGH_W
) (
  input logic               clk,
  input logic               rstN,
  input logic               runEn,
  input logic               cntPulse,
  input logic               readStb,
  input logic               flagClr,
  input logic [LOW_W-1:0]   lowCount,
  input logic [HIGH_W-1:0]  highCount,
  input logic               lowOvf,
  input logic               snapValid,
  input logic [TOTAL_W-1:0] snapValue
);

  AST_START_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    $rose(runEn) |=> lowCount == '0); // R2

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    runEn && !cntPulse |=> $stable(lowCount)); // R2

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    runEn && lowOvf && !flagClr |=> lowOvf); // R4

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    flagClr |=> !lowOvf); // R5

  AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    runEn && !(cntPulse && lowCount == '1) |=> $stable(highCount)); // R6

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> lowCount == '0 && highCount == '0 && !lowOvf); // R8

  AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    readStb |=> snapValid); // R9

  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    snapValid |-> $past(readStb)); // R9

endmodule

bind cascadeEventCounter cecChecker #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) i_checker (.*);

// File: tb/test_cascadeEventCounter.sv
module test_cascadeEventCounter;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, runEn, cntPulse, readStb, flagClr;

  logic [7:0]  lowCount;
  logic [15:0] highCount;
  logic        lowOvf, snapValid;
  logic [23:0] snapValue;

  logic [1:0]  lowCountS;
  logic [2:0]  highCountS;
  logic        lowOvfS, snapValidS;
  logic [4:0]  snapValueS;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model of both instances (widths 8/16 and 2/3).
  logic [7:0]  mLow;  logic [15:0] mHigh; logic mFlag, mSwallow;
  logic [1:0]  sLow;  logic [2:0]  sHigh; logic sFlag, sSwallow;
  logic        mRunSeen;

  logic [23:0] qMain[$];
  logic [4:0]  qSmall[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cascadeEventCounter i_cascadeEventCounter (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cntPulse(cntPulse),
    .readStb(readStb), .flagClr(flagClr), .lowCount(lowCount),
    .highCount(highCount), .lowOvf(lowOvf), .snapValid(snapValid),
    .snapValue(snapValue)
  );

  cascadeEventCounter #(.LOW_W(2), .HIGH_W(3)) i_cascadeEventCounterSmall (
    .clk(clk), .rstN(rstN), .runEn(runEn), .cntPulse(cntPulse),
    .readStb(readStb), .flagClr(flagClr), .lowCount(lowCountS),
    .highCount(highCountS), .lowOvf(lowOvfS), .snapValid(snapValidS),
    .snapValue(snapValueS)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Advance the model by one clock with the inputs now driven, then wait.
  task automatic tick();
    logic inc, wrapM, wrapS;
    if (!rstN) begin
      mLow = '0; mHigh = '0; mFlag = 0; mSwallow = 1;
      sLow = '0; sHigh = '0; sFlag = 0; sSwallow = 1;
      mRunSeen = 0;
    end else begin
      inc   = runEn && mRunSeen && cntPulse;
      wrapM = inc && (mLow == 8'hFF);
      wrapS = inc && (sLow == 2'h3);
      if (!runEn) begin
        mLow = '0; mHigh = '0; mFlag = 0; mSwallow = 1;
        sLow = '0; sHigh = '0; sFlag = 0; sSwallow = 1;
      end else begin
        if (inc) begin mLow = mLow + 8'd1; sLow = sLow + 2'd1; end
        if (wrapM && !mSwallow) mHigh = mHigh + 16'd1;
        if (wrapS && !sSwallow) sHigh = sHigh + 3'd1;
        if (wrapM) mSwallow = 0;
        if (wrapS) sSwallow = 0;
        if (flagClr) mFlag = 0; else if (wrapM) mFlag = 1;
        if (flagClr) sFlag = 0; else if (wrapS) sFlag = 1;
      end
      mRunSeen = runEn;
    end
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      cntPulse = 1; tick(); cntPulse = 0;
    end
  endtask

  task automatic checkRaw(input string req);
    chk(req, "lowCount", 32'(lowCount), 32'(mLow));
    chk(req, "highCount", 32'(highCount), 32'(mHigh));
    chk(req, "lowOvf", 32'(lowOvf), 32'(mFlag));
    chk(req, "lowCountS", 32'(lowCountS), 32'(sLow));
    chk(req, "highCountS", 32'(highCountS), 32'(sHigh));
    chk(req, "lowOvfS", 32'(lowOvfS), 32'(sFlag));
  endtask

  // Driver side of the scoreboard: expected snapshots from the model.
  task automatic readSnap();
    logic [15:0] hm; logic [2:0] hs;
    hm = mHigh + 16'(mFlag);
    hs = sHigh + 3'(sFlag);
    qMain.push_back({hm, mLow});
    qSmall.push_back({hs, sLow});
    readStb = 1; tick(); readStb = 0;
    chk("R9", "snapValid after read", 32'(snapValid), 32'd1);
    tick();
    chk("R9", "snapValid one cycle", 32'(snapValid), 32'd0);
  endtask

  // Monitor side of the scoreboard (R10).
  always @(negedge clk) begin
    if (rstN === 1'b1 && !finished) begin
      if (snapValid === 1'b1) begin
        checks++;
        if (qMain.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected snapValid actual=1 expected=0");
        end else begin
          logic [23:0] e;
          e = qMain.pop_front();
          if (snapValue !== e) begin
            errors++;
            $display("FAIL R10 snapValue actual=%0h expected=%0h", snapValue, e);
          end
        end
      end
      if (snapValidS === 1'b1) begin
        checks++;
        if (qSmall.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected snapValidS actual=1 expected=0");
        end else begin
          logic [4:0] e;
          e = qSmall.pop_front();
          if (snapValueS !== e) begin
            errors++;
            $display("FAIL R10 snapValueS actual=%0h expected=%0h", snapValueS, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; runEn = 0; cntPulse = 0; readStb = 0; flagClr = 0;
    @(negedge clk);
    tick(); tick();
    // R1 reset state
    chk("R1", "lowCount", 32'(lowCount), 0);
    chk("R1", "highCount", 32'(highCount), 0);
    chk("R1", "lowOvf", 32'(lowOvf), 0);
    chk("R1", "snapValid", 32'(snapValid), 0);
    chk("R1", "snapValue", 32'(snapValue), 0);
    rstN = 1; tick();

    // R3 stopped pulses ignored
    pulses(5);
    chk("R3", "lowCount stopped", 32'(lowCount), 0);

    // R2 first run cycle ignores the strobe
    runEn = 1; cntPulse = 1; tick(); cntPulse = 0;
    chk("R2", "first-cycle pulse", 32'(lowCount), 0);
    pulses(10);
    chk("R2", "ten pulses", 32'(lowCount), 10);
    repeat (4) tick();
    chk("R2", "hold without pulse", 32'(lowCount), 10);
    checkRaw("R2");

    // R10 clear flag: raw values unchanged
    readSnap();

    pulses(245);
    chk("R4", "no flag before wrap", 32'(lowOvf), 0);
    chk("R2", "low at max", 32'(lowCount), 32'hFF);
    pulses(1);
    chk("R4", "flag on wrap", 32'(lowOvf), 1);
    chk("R6", "first upper pulse dropped", 32'(highCount), 0);
    checkRaw("R6");
    tick();
    chk("R4", "flag holds", 32'(lowOvf), 1);

    // R10 flag set: upper plus one, expected {1,00}
    readSnap();

    flagClr = 1; tick(); flagClr = 0;
    chk("R5", "flag cleared", 32'(lowOvf), 0);
    pulses(256);
    chk("R6", "second wrap counted", 32'(highCount), 1);
    chk("R4", "flag set again", 32'(lowOvf), 1);
    flagClr = 1; tick(); flagClr = 0;
    pulses(255);
    cntPulse = 1; flagClr = 1; tick(); cntPulse = 0; flagClr = 0;
    chk("R5", "clear wins over set", 32'(lowOvf), 0);
    chk("R6", "third wrap counted", 32'(highCount), 2);
    checkRaw("R5");
    readSnap();

    // R8 stop clears, restart re-arms the drop
    runEn = 0; tick();
    chk("R8", "low cleared", 32'(lowCount), 0);
    chk("R8", "high cleared", 32'(highCount), 0);
    chk("R8", "flag cleared", 32'(lowOvf), 0);
    checkRaw("R8");
    runEn = 1; tick();
    pulses(32);
    chk("R6", "small upper at max", 32'(highCountS), 7);
    chk("R4", "small flag", 32'(lowOvfS), 1);
    readSnap();
    chk("R10", "wrapped correction", 32'(snapValueS), 0);
    pulses(4);
    chk("R7", "small upper wraps", 32'(highCountS), 0);
    pulses(4);
    chk("R7", "no lost pulse after wrap", 32'(highCountS), 1);
    pulses(216);
    chk("R8", "main drop re-armed", 32'(highCount), 0);
    chk("R8", "main low wrapped", 32'(lowCount), 0);
    checkRaw("R8");
    readSnap();
    tick(); tick();
    chk("R9", "scoreboard drained", 32'(qMain.size() + qSmall.size()), 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule